// File: doc/BRIEF.md
# Floating-point condition predicate evaluator

This block decides whether a floating-point conditional instruction (branch, set-on-condition or trap-on-condition) is taken. It takes a 6-bit predicate field and the three condition bits of the floating-point status: negative, zero and not-a-number. It returns a registered true/false verdict, a flag for predicates outside the legal range, and a request to set the branch-on-unordered exception bit. The surrounding pipeline pulses a one-cycle evaluate strobe and reads the outputs one clock later. Branch target arithmetic and the exception byte itself belong to the caller.

The predicate is folded before evaluation, so only eight base relations are built. Bit 4 selects the signalling, NaN-unaware form of the test, which evaluates the same relation on the low four bits. Bit 3 complements both the relation code and the final outcome. Any predicate with bit 5 set is illegal. A signalling test that meets a set NaN bit raises the unordered request whether the verdict is true or false.

Top module: `flt_pred_eval`

## Requirements
- R1: A strobed predicate of 0x20 or above (bit 5 set) gives illegal_o = 1 with result_o = 0 and bsun_set_o = 0.
- R2: Outputs are registered: a strobe in cycle t gives valid_o = 1 in cycle t+1. A cycle after a non-strobe cycle, and during reset, all four outputs are 0. Strobes may come in consecutive cycles.
- R3: With bits 5, 4 and 3 clear, base code 0 (predicate bits 2:0) is always false and code 1 is true exactly when Z is set.
- R4: Code 2 is true when NaN, Z and N are all clear. Code 4 is true when N is set and both NaN and Z are clear.
- R5: Code 3 is true when Z is set, or when NaN and N are both clear. Code 5 is true when Z is set, or when N is set and NaN is clear.
- R6: Code 6 is true when NaN and Z are both clear. Code 7 is true when NaN is clear.
- R7: With predicate bit 3 set, the low four bits are XORed with 0xF, the resulting base code is evaluated, and the outcome is inverted. So 0x0F is always true and 0x0E is true when Z is clear.
- R8: With predicate bit 4 set (and bit 5 clear), the verdict equals the one that bits 3:0 give with bit 4 clear.
- R9: A legal predicate with bit 4 set and NaN set gives bsun_set_o = 1 regardless of result_o. A predicate with bit 4 clear never gives bsun_set_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe, one cycle per predicate |
| pred_i | input | 6 | Conditional predicate field |
| cc_neg_i | input | 1 | Condition bit: result negative |
| cc_zero_i | input | 1 | Condition bit: result zero |
| cc_nan_i | input | 1 | Condition bit: result not-a-number |
| valid_o | output | 1 | Outputs below belong to the previous cycle's strobe |
| result_o | output | 1 | Predicate verdict (1 = true) |
| illegal_o | output | 1 | Predicate outside the legal range |
| bsun_set_o | output | 1 | Request to set the branch-on-unordered exception bit |

## Verification
The verdict and the unordered request can both come out of one evaluation, and both must be correct in the same cycle. This happens whenever a signalling predicate is strobed with NaN set. The bench sweeps all signalling predicates against every condition combination that has NaN set, in back-to-back strobes. For each one it compares result_o and bsun_set_o in the cycle after the strobe against its own model, including the inverted cases where the verdict is true while the request fires.

// File: rtl/flt_pred_pkg.sv
package flt_pred_pkg;

    // Predicate field layout
    localparam int PRED_W    = 6;
    localparam int CODE_W    = 3;
    localparam int ILL_BIT   = 5;
    localparam int SIG_BIT   = 4;
    localparam int INV_BIT   = 3;
    localparam int NUM_CODES = 1 << CODE_W;

    // Folded view of a predicate
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              invert;
        logic              signalling;
        logic              illegal;
    } pred_fold_t;

    // Registered output state
    typedef struct packed {
        logic valid;
        logic result;
        logic illegal;
        logic bsun;
    } pred_out_t;

endpackage

// File: rtl/flt_pred_fold.sv
module flt_pred_fold
    import flt_pred_pkg::*;
(
    input  logic [PRED_W-1:0] pred_i,
    output pred_fold_t        fold_o
);

    logic [CODE_W-1:0] raw_code;

    always_comb begin
        raw_code          = pred_i[CODE_W-1:0];
        fold_o.illegal    = pred_i[ILL_BIT];
        fold_o.signalling = pred_i[SIG_BIT];
        fold_o.invert     = pred_i[INV_BIT];
        // XOR of the low nibble with all ones; bit 3 becomes 0, so only
        // the low code bits need complementing.
        fold_o.code       = raw_code ^ {CODE_W{pred_i[INV_BIT]}};
    end

endmodule

// File: rtl/flt_pred_rel.sv
module flt_pred_rel
    import flt_pred_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              neg_i,
    input  logic              zero_i,
    input  logic              nan_i,
    output logic              hit_o
);

    logic [NUM_CODES-1:0] rel_vec;

    // One relation per base code
    genvar g;
    generate
        for (g = 0; g < NUM_CODES; g++) begin : g_rel
            if (g == 0) begin : g_false
                assign rel_vec[g] = 1'b0;
            end else if (g == 1) begin : g_eq
                assign rel_vec[g] = zero_i;
            end else if (g == 2) begin : g_gt
                assign rel_vec[g] = !nan_i && !zero_i && !neg_i;
            end else if (g == 3) begin : g_ge
                assign rel_vec[g] = zero_i || (!nan_i && !neg_i);
            end else if (g == 4) begin : g_lt
                assign rel_vec[g] = neg_i && !nan_i && !zero_i;
            end else if (g == 5) begin : g_le
                assign rel_vec[g] = zero_i || (neg_i && !nan_i);
            end else if (g == 6) begin : g_gl
                assign rel_vec[g] = !nan_i && !zero_i;
            end else begin : g_gle
                assign rel_vec[g] = !nan_i;
            end
        end
    endgenerate

    assign hit_o = rel_vec[code_i];

endmodule

// File: rtl/flt_pred_eval.sv
module flt_pred_eval
    import flt_pred_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              cc_neg_i,
    input  logic              cc_zero_i,
    input  logic              cc_nan_i,
    output logic              valid_o,
    output logic              result_o,
    output logic              illegal_o,
    output logic              bsun_set_o
);

    pred_fold_t fold;
    logic       rel_hit;
    pred_out_t  st_d, st_q;

    flt_pred_fold u_fold (
        .pred_i (pred_i),
        .fold_o (fold)
    );

    flt_pred_rel u_rel (
        .code_i (fold.code),
        .neg_i  (cc_neg_i),
        .zero_i (cc_zero_i),
        .nan_i  (cc_nan_i),
        .hit_o  (rel_hit)
    );

    always_comb begin
        st_d = '0;
        if (eval_i) begin
            st_d.valid   = 1'b1;
            st_d.illegal = fold.illegal;
            if (!fold.illegal) begin
                st_d.result = rel_hit ^ fold.invert;
                st_d.bsun   = fold.signalling && cc_nan_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o    = st_q.valid;
    assign result_o   = st_q.result;
    assign illegal_o  = st_q.illegal;
    assign bsun_set_o = st_q.bsun;

    // R1
    illegal_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i && pred_i[ILL_BIT] |=> illegal_o && !result_o && !bsun_set_o);

    // R2
    strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> valid_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> !valid_o && !result_o && !illegal_o && !bsun_set_o);

    // R7
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i && (pred_i[PRED_W-2:0] == 5'h0F) && !pred_i[ILL_BIT] |=> result_o);

    // R3
    always_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i && (pred_i == 6'h00) |=> !result_o);

    // R6
    ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i && (pred_i == 6'h07) && !cc_nan_i |=> result_o);

    // R9
    bsun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i && !pred_i[ILL_BIT] && pred_i[SIG_BIT] && cc_nan_i |=> bsun_set_o);

    // R9
    aware_no_bsun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i && !pred_i[SIG_BIT] |=> !bsun_set_o);

endmodule

// File: tb/flt_pred_eval_bench.sv
module flt_pred_eval_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eval_i = 1'b0;
    logic [5:0] pred_i = '0;
    logic       cc_neg_i = 1'b0;
    logic       cc_zero_i = 1'b0;
    logic       cc_nan_i = 1'b0;
    logic       valid_o, result_o, illegal_o, bsun_set_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    flt_pred_eval u_flt_pred_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_i     (eval_i),
        .pred_i     (pred_i),
        .cc_neg_i   (cc_neg_i),
        .cc_zero_i  (cc_zero_i),
        .cc_nan_i   (cc_nan_i),
        .valid_o    (valid_o),
        .result_o   (result_o),
        .illegal_o  (illegal_o),
        .bsun_set_o (bsun_set_o)
    );

    // Expected {valid, result, illegal, bsun} from the requirements
    function automatic logic [3:0] model(input logic [5:0] p, input logic n,
                                         input logic z, input logic nan);
        logic [3:0] low;
        logic       inv, r;
        if (p[5]) return 4'b1010;                 // R1
        low = p[3:0];
        inv = low[3];
        if (inv) low = low ^ 4'hF;                // R7
        case (low[2:0])
            3'd0: r = 1'b0;
            3'd1: r = z;
            3'd2: r = !nan && !z && !n;
            3'd3: r = z || (!nan && !n);
            3'd4: r = n && !nan && !z;
            3'd5: r = z || (n && !nan);
            3'd6: r = !nan && !z;
            default: r = !nan;
        endcase
        r = r ^ inv;
        return {1'b1, r, 1'b0, p[4] && nan};      // R9
    endfunction

    function automatic string tag(input logic [5:0] p, input logic nan);
        if (p[5]) return "R1";
        if (p[4] && nan) return "R9";
        if (p[4]) return "R8";
        if (p[3]) return "R7";
        case (p[2:0])
            3'd0, 3'd1: return "R3";
            3'd2, 3'd4: return "R4";
            3'd3, 3'd5: return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic compare(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {valid_o, result_o, illegal_o, bsun_set_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {valid,result,illegal,bsun} actual=%b expected=%b",
                     req, act, exp);
        end
    endtask

    // Drive a strobe at a falling edge; check at the next falling edge.
    task automatic strobe(input logic [5:0] p, input logic n, input logic z,
                          input logic nan);
        eval_i    = 1'b1;
        pred_i    = p;
        cc_neg_i  = n;
        cc_zero_i = z;
        cc_nan_i  = nan;
        @(negedge clk);
        compare(model(p, n, z, nan), tag(p, nan));
    endtask

    task automatic idle_check(input logic [5:0] p, input logic nan);
        eval_i   = 1'b0;
        pred_i   = p;
        cc_nan_i = nan;
        @(negedge clk);
        compare(4'b0000, "R2");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        compare(4'b0000, "R2");                   // reset state
        rst_n = 1'b1;
        @(negedge clk);
        compare(4'b0000, "R2");                   // idle after reset

        // Directed: every legal predicate against every condition combination
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 8; c++) begin
                strobe(6'(p), c[2], c[1], c[0]);
            end
        end
        idle_check(6'h3F, 1'b1);                  // R2 quiet after stream

        // R1: illegal range edges
        strobe(6'h20, 1'b0, 1'b1, 1'b0);
        strobe(6'h3F, 1'b1, 1'b0, 1'b1);
        strobe(6'h1F, 1'b1, 1'b0, 1'b1);          // last legal, signalling
        idle_check(6'h11, 1'b1);                  // R2: no strobe, no request

        // R8: signalling verdict equals aware verdict
        for (int p = 0; p < 16; p++) begin
            strobe(6'(p) | 6'h10, 1'b1, 1'b0, 1'b0);
            if (result_o !== model(6'(p), 1'b1, 1'b0, 1'b0)[2]) begin
                n_bad++;
                $display("FAIL R8: result actual=%b expected=%b", result_o,
                         model(6'(p), 1'b1, 1'b0, 1'b0)[2]);
            end
            n_cmp++;
        end

        // Random mix with occasional idle cycles
        for (int i = 0; i < 2000; i++) begin
            logic [5:0] rp;
            logic [2:0] rc;
            rp = 6'($urandom_range(0, 63));
            rc = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) idle_check(rp, rc[0]);
            else strobe(rp, rc[2], rc[1], rc[0]);
        end

        idle_check(6'h00, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule